// File: doc/BRIEF.md
# Command-Paced SPI Slave with Ready Line and Interface Lock

This block is the serial front end of a peripheral that only ever answers a host. The host clocks command bytes in over a four-wire SPI link (clock idling high, data sampled on the clock's rising edge, most significant bit first), and the block hands each complete byte to the internal core with a one-cycle strobe. The core answers by loading a response byte, which the host collects by clocking in a dummy byte on the next transfer. The block never starts a transfer by itself.

An active-high ready output paces the host. It falls after every received byte and stays low until the core says it can take another one. A small claim latch watches both the SPI select and a competing UART receive line. Whichever shows host activity first after reset becomes the only live interface. The other is ignored until the next reset. All pin inputs pass through two-flop synchronisers into the system clock, which must run at least eight times the SCK rate.

Top module: `spi_ready_slave`

## Requirements
- R1: After reset, `ready` is 1, `miso_oe` is 0, and both `spi_sel` and `uart_sel` are 0.
- R2: While the SPI link is live and `ss_n` is low, `mosi` is sampled on each rising edge of `sck`, most significant bit first. After the eighth rising edge, `rx_byte` holds the byte and `rx_valid` is high for exactly one system clock cycle.
- R3: `ready` goes to 0 in the cycle after every `rx_valid`, even when `core_ready` is already high. It returns to 1 only after a cycle in which `core_ready` was 1.
- R4: `miso_oe` is 1 only while the SPI link is live and the synchronised `ss_n` is low, and `miso` is 0 while `miso_oe` is 0. The response byte given with `tx_load` is driven on `miso` most significant bit first. Each bit appears after a falling edge of `sck`, and bit 7 appears after the first falling edge of the byte.
- R5: If no response byte is pending when the first falling edge of a byte arrives, the block shifts out 0x00. A loaded response is used by exactly one transfer, so the following transfer returns 0x00 unless a new byte is loaded.
- R6: If `ss_n` rises before the eighth rising edge, the partial byte is discarded: no `rx_valid` is produced, `ready` is unchanged, and the next byte starts again from bit 7.
- R7: The first host activity after reset locks the mode until the next reset. Host activity is `ss_n` low for SPI and `uart_rx` low for UART. SPI sets `spi_sel`=1 and UART sets `uart_sel`=1. If both appear in the same cycle, SPI wins. Activity on the other interface afterwards does not change the lock.
- R8: Once UART is locked, SPI pin activity is ignored: no `rx_valid`, `miso_oe` stays 0, and `ready` is unchanged.
- R9: R2 and R4 hold at an SCK period as short as 8 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI clock from host, idles high |
| mosi | input | 1 | Serial data from host |
| ss_n | input | 1 | Active-low select from host |
| uart_rx | input | 1 | Competing UART receive line, idles high, watched only for the claim |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad |
| ready | output | 1 | Active-high pacing line to host |
| rx_byte | output | 8 | Last received command byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_byte` is new |
| core_ready | input | 1 | Core can accept another byte |
| tx_byte | input | 8 | Response byte from core |
| tx_load | input | 1 | Load `tx_byte` as the pending response |
| spi_sel | output | 1 | SPI link is locked in |
| uart_sel | output | 1 | UART link is locked in |

## Verification
The hardest situation to reach is the losing side of the claim. Once UART is locked, a full, well-formed SPI byte must leave no trace at all. The only evidence of that is missing behaviour across several outputs. The bench resets, pulses `uart_rx` low before any SPI activity, and then drives a complete SPI transfer. Its scoreboard expects nothing, so any strobe is reported, and it checks `miso_oe` and `ready` during and after the byte. The aborted byte is reached the same way: the bench drives four clock edges, raises select, and then sends a full byte whose value must arrive unmixed.

// File: rtl/spi_ready_slave_pkg.sv
// Package: shared types for the ready-paced SPI slave.
package spi_ready_slave_pkg;

    // Which host interface has claimed the device since reset.
    typedef enum logic [1:0] {
        LINK_NONE = 2'd0,
        LINK_SPI  = 2'd1,
        LINK_UART = 2'd2
    } link_t;

endpackage

// File: rtl/srs_sync.sv
// srs_sync: multi-bit, multi-stage synchroniser into the system clock.
// Assumes each bit is an independent slow signal, so bits are not kept
// coherent with each other. The reset value gives each bit its idle level.
module srs_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/srs_link_lock.sv
// srs_link_lock: claims the device for the first host interface that shows
// activity after reset. Assumes synchronised inputs. SPI wins a same-cycle tie.
module srs_link_lock
    import spi_ready_slave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spi_act,
    input  logic uart_act,
    output logic spi_en,
    output logic spi_sel,
    output logic uart_sel
);

    link_t link_q;

    // Latch the first claimant and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= LINK_NONE;
        end else if (link_q == LINK_NONE) begin
            if (spi_act)       link_q <= LINK_SPI;
            else if (uart_act) link_q <= LINK_UART;
        end
    end

    assign spi_en   = (link_q != LINK_UART);
    assign spi_sel  = (link_q == LINK_SPI);
    assign uart_sel = (link_q == LINK_UART);

endmodule

// File: rtl/srs_shift.sv
// srs_shift: SPI byte engine. SCK idles high. MOSI is taken on the rising
// edge and MISO is advanced on the falling edge, MSB first. Assumes
// synchronised pins and a system clock at least 8x SCK. Raising select
// drops any partial byte.
module srs_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ss_n_s,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              miso,
    output logic              miso_oe
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic              sck_prev;
    logic              active, rise, fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] resp_q;
    logic              resp_full;
    logic              miso_q;
    logic [DATA_W-1:0] tx_src;

    assign active = en & ~ss_n_s;
    assign rise   = active &  sck_s & ~sck_prev;
    assign fall   = active & ~sck_s &  sck_prev;
    assign tx_src = resp_full ? resp_q : '0;

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_s;
    end

    // Count bits and assemble the received byte on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
            end else if (rise) begin
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_byte  <= {rx_sh[DATA_W-2:0], mosi_s};
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
                end
            end
        end
    end

    // Hold the core's pending response until a byte's first falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q    <= '0;
            resp_full <= 1'b0;
        end else if (tx_load) begin
            resp_q    <= tx_byte;
            resp_full <= 1'b1;
        end else if (fall && bit_cnt == '0) begin
            resp_full <= 1'b0;
        end
    end

    // Drive the next response bit after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (fall) begin
            if (bit_cnt == '0) begin
                miso_q <= tx_src[DATA_W-1];
                tx_sh  <= {tx_src[DATA_W-2:0], 1'b0};
            end else begin
                miso_q <= tx_sh[DATA_W-1];
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso_oe = active;
    assign miso    = active & miso_q;

endmodule

// File: rtl/srs_ready_pace.sv
// srs_ready_pace: drops the host ready line after every received byte and
// holds it low until the core reports it can accept another.
module srs_ready_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic core_ready,
    output logic ready
);

    logic busy_q;

    // Set busy on a completed byte and clear it on core acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (byte_done) busy_q <= 1'b1;
        else if (core_ready) busy_q <= 1'b0;
    end

    assign ready = ~busy_q;

endmodule

// File: rtl/spi_ready_slave.sv
// spi_ready_slave: host-driven SPI slave with a ready pacing line and a
// first-come SPI/UART interface claim. Assumes clk >= 8x SCK. The UART
// receive line is only watched for the claim.
module spi_ready_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    input  logic              uart_rx,
    output logic              miso,
    output logic              miso_oe,
    output logic              ready,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    input  logic              core_ready,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_load,
    output logic              spi_sel,
    output logic              uart_sel
);

    // Pin bundle order: {uart_rx, ss_n, mosi, sck}; idle levels 1,1,0,1.
    localparam int         PIN_W    = 4;
    localparam logic [3:0] PIN_IDLE = 4'b1101;

    logic [PIN_W-1:0] pins_s;
    logic             spi_en;

    srs_sync #(
        .WIDTH    (PIN_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({uart_rx, ss_n, mosi, sck}),
        .q    (pins_s)
    );

    srs_link_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_act (~pins_s[2]),
        .uart_act(~pins_s[3]),
        .spi_en  (spi_en),
        .spi_sel (spi_sel),
        .uart_sel(uart_sel)
    );

    srs_shift #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (spi_en),
        .sck_s   (pins_s[0]),
        .mosi_s  (pins_s[1]),
        .ss_n_s  (pins_s[2]),
        .tx_byte (tx_byte),
        .tx_load (tx_load),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    srs_ready_pace u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (rx_valid),
        .core_ready(core_ready),
        .ready     (ready)
    );

endmodule

// File: rtl/srs_checker.sv
// srs_checker: temporal properties of spi_ready_slave, bound to the top.
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic ready,
    input logic core_ready,
    input logic miso,
    input logic miso_oe,
    input logic spi_sel,
    input logic uart_sel
);

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !ready);

    a_r3_ready_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(core_ready));

    a_r4_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(spi_sel && uart_sel));

    a_r7_spi_held: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel |=> spi_sel);

    a_r7_uart_held: assert property (@(posedge clk) disable iff (!rst_n)
        uart_sel |=> uart_sel);

    a_r8_uart_no_spi: assert property (@(posedge clk) disable iff (!rst_n)
        uart_sel |-> (!rx_valid && !miso_oe));

endmodule

bind spi_ready_slave srs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .ready     (ready),
    .core_ready(core_ready),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .spi_sel   (spi_sel),
    .uart_sel  (uart_sel)
);

// File: tb/tb_spi_ready_slave.sv
module tb_spi_ready_slave;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1, mosi = 1'b0, ss_n = 1'b1, uart_rx = 1'b1;
    logic       miso, miso_oe, ready, rx_valid, spi_sel, uart_sel;
    logic [7:0] rx_byte;
    logic       core_ready = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;

    int   total = 0, bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ready_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .uart_rx(uart_rx), .miso(miso), .miso_oe(miso_oe), .ready(ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .core_ready(core_ready),
        .tx_byte(tx_byte), .tx_load(tx_load), .spi_sel(spi_sel),
        .uart_sel(uart_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every strobe (R2, R6, R8).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_rx.size() == 0) begin
                check(1'b0, "R2/R6/R8 unexpected rx_valid", rx_byte, 0);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_byte == e, "R2 rx_byte", rx_byte, e);
            end
        end
    end

    task automatic do_reset;
        rst_n = 1'b0; sck = 1'b1; ss_n = 1'b1; uart_rx = 1'b1; mosi = 1'b0;
        core_ready = 1'b0; tx_load = 1'b0;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
    endtask

    task automatic load_resp(input logic [7:0] v);
        tx_byte = v; tx_load = 1'b1;
        wait_clks(1);
        tx_load = 1'b0;
    endtask

    // Clock bits [7 .. 7-nbits+1] of v; returns what MISO showed.
    task automatic clock_bits(input logic [7:0] v, input int nbits, input int half,
                              output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            sck = 1'b0; mosi = v[i];
            wait_clks(half);
            got[i] = miso;
            sck = 1'b1;
            wait_clks(half);
        end
    endtask

    // Driver: one framed byte. live=1 expects a strobe and a response.
    task automatic xfer(input logic [7:0] v, input int half, input bit live,
                        input logic [7:0] exp_miso, input string tag);
        logic [7:0] got;
        if (live) exp_rx.push_back(v);
        ss_n = 1'b0;
        wait_clks(half);
        check(miso_oe == live, {tag, " R4/R8 miso_oe in frame"}, miso_oe, live);
        clock_bits(v, 8, half, got);
        if (live) check(got == exp_miso, {tag, " R4/R5 miso byte"}, got, exp_miso);
        wait_clks(half);
        ss_n = 1'b1;
        wait_clks(half + 4);
        check(miso_oe == 1'b0, {tag, " R4 miso_oe after frame"}, miso_oe, 0);
    endtask

    task automatic release_core;
        core_ready = 1'b1;
        wait_clks(1);
        core_ready = 1'b0;
        wait_clks(1);
        check(ready == 1'b1, "R3 ready back after core_ready", ready, 1);
    endtask

    initial begin
        logic [7:0] junk;
        do_reset();
        // R1 reset state
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(miso_oe == 1'b0, "R1 miso_oe", miso_oe, 0);
        check(spi_sel == 1'b0 && uart_sel == 1'b0, "R1 no lock", {spi_sel, uart_sel}, 0);

        // R2/R5: first byte without a response gives 0x00
        xfer(8'hA5, 8, 1'b1, 8'h00, "R2 byte1");
        check(spi_sel == 1'b1, "R7 spi locked", spi_sel, 1);
        check(ready == 1'b0, "R3 ready low after byte", ready, 0);
        wait_clks(20);
        check(ready == 1'b0, "R3 ready held while busy", ready, 0);
        release_core();

        // R4: loaded response comes out MSB first
        load_resp(8'hC3);
        xfer(8'h3C, 8, 1'b1, 8'hC3, "R4 resp C3");
        release_core();
        // R5: response used once
        xfer(8'hFF, 8, 1'b1, 8'h00, "R5 consumed");
        release_core();

        // R3: ready drops even when core_ready already high
        core_ready = 1'b1;
        exp_rx.push_back(8'h81);
        ss_n = 1'b0; wait_clks(8);
        clock_bits(8'h81, 8, 8, junk);
        core_ready = 1'b1;
        ss_n = 1'b1; wait_clks(8);
        check(ready == 1'b1, "R3 ready recovers with core_ready high", ready, 1);
        core_ready = 1'b0;

        // R9: fastest SCK, period 8 clocks
        load_resp(8'h5A);
        xfer(8'h96, 4, 1'b1, 8'h5A, "R9 fast");
        release_core();
        load_resp(8'h01);
        xfer(8'h00, 4, 1'b1, 8'h01, "R9 fast2");
        release_core();

        // R6: abort mid byte, then a clean byte
        ss_n = 1'b0; wait_clks(8);
        clock_bits(8'hF0, 4, 8, junk);
        ss_n = 1'b1; wait_clks(12);
        check(ready == 1'b1, "R6 ready untouched by abort", ready, 1);
        xfer(8'h69, 8, 1'b1, 8'h00, "R6 after abort");
        release_core();

        // R7: UART activity after SPI lock is ignored
        uart_rx = 1'b0; wait_clks(6); uart_rx = 1'b1; wait_clks(4);
        check(spi_sel == 1'b1 && uart_sel == 1'b0, "R7 spi keeps lock", {spi_sel, uart_sel}, 2);

        // R7/R8: UART first, SPI ignored
        do_reset();
        uart_rx = 1'b0; wait_clks(6); uart_rx = 1'b1; wait_clks(4);
        check(uart_sel == 1'b1 && spi_sel == 1'b0, "R7 uart locked", {spi_sel, uart_sel}, 1);
        load_resp(8'hEE);
        xfer(8'h42, 8, 1'b0, 8'h00, "R8 ignored");
        check(ready == 1'b1, "R8 ready unchanged", ready, 1);
        check(uart_sel == 1'b1, "R7 uart keeps lock", uart_sel, 1);

        // R7: same-cycle tie, SPI wins
        do_reset();
        ss_n = 1'b0; uart_rx = 1'b0;
        wait_clks(6);
        check(spi_sel == 1'b1 && uart_sel == 1'b0, "R7 tie to spi", {spi_sel, uart_sel}, 2);
        ss_n = 1'b1; uart_rx = 1'b1;
        wait_clks(6);

        check(exp_rx.size() == 0, "R2 all bytes seen", exp_rx.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule